// File: doc/BRIEF.md
# Cable Test Reflection Sequencer

This block runs one cable diagnostic pass on a single twisted pair and records what the pass found. Software programs the silence windows, the transmit amplitude, the transmit length and a tap window through a small register interface. It then sets the start bit in the control register. The block first keeps the line quiet for the pre-silence window. It then raises the transmit enable of an external modulated-signal generator for the programmed number of microsecond ticks, and keeps the line quiet again for the post-silence window. Finally it holds the port in forced-link mode until the next start.

The block samples an external reflection detector (peak found, peak sign, 10-bit peak location) on the last transmit cycle. A peak whose location lies outside the programmed tap window is discarded. When the run ends, the block writes a result code, a fault status word and the done and fail flags. If a link partner was seen transmitting at any point of the modulated phase, the run is marked as failed and no peak is kept. Silence windows are timed in milliseconds by a counter that divides the 1 µs tick input.

Top module: `cable_tdr_seq`

## Requirements
- R1: After reset, tx_en and force_link are low. A run passes through pre-silence, transmit, post-silence and forced-link in that order. tx_en is high only in the transmit phase, force_link is high only in the forced-link phase, and the two are never high together.
- R2: The 2-bit silence codes are pre-silence in bits 1:0 and post-silence in bits 3:2 of config register 1 (address 0x10). Codes 0, 1, 2 and 3 select 0, 10, 100 and 1000 ms, where one ms is US_PER_MS ticks. A zero code passes that phase in one clock cycle. Counted in clock edges, pre-silence runs from the start write until tx_en rises and lasts 1 + max(ms·US_PER_MS, 1) edges. Post-silence lasts max(ms·US_PER_MS, 1) edges.
- R3: The transmit length is a 16-bit tick count in the duration register (address 0x12), reset value 16000. tx_en stays high for that many ticks, and for one tick when the count is 0.
- R4: Bit 12 of config register 1 (0 = low, 1 = high amplitude) drives tx_amp_hi directly.
- R5: The control register is at address 0x1E. Writing 1 to bit 15 starts a run; bit 15 reads 1 only until the sequence leaves idle. Bit 1 is done and bit 0 is fail, and bits 5:4 hold the result code. Done rises on the same clock edge as force_link.
- R6: A start written while a run is in pre-silence, transmit or post-silence is ignored. Bit 15 stays 0 and the phase timing is unchanged.
- R7: The fault status register is at address 0x13. Bit 11 means peak detected, bit 10 is the peak sign and bits 9:0 are the raw peak location. The result code is 1 (open) for a sign of 1, 2 (short) for a sign of 0 and 0 (OK) when no peak is kept.
- R8: Config register 2 (address 0x11) holds the start tap in bits 6:0 (reset 4) and the end tap in bits 14:8 (reset 36). A peak is kept only if start ≤ location ≤ end. Otherwise the fault status register reads 0 and the result is OK.
- R9: If link_partner_active is high in any transmit-phase cycle, including the final one, the run ends with done = 1, fail = 1, result code 3 and a fault status of 0.
- R10: Reset values read back as config register 1 = 0x0000, config register 2 = 0x2404, duration = 0x3E80 and control = 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| link_partner_active | input | 1 | Remote transmitter detected on the pair |
| peak_found | input | 1 | Detector found a reflection peak |
| peak_sign | input | 1 | Peak sign, 1 = positive |
| peak_loc | input | 10 | Peak location in detector units |
| tx_en | output | 1 | Enable for the modulated transmitter |
| tx_amp_hi | output | 1 | Transmit amplitude select |
| force_link | output | 1 | Forced-link mode request |
| result_code | output | 2 | Result of the last finished run |

## Verification
Two events can fall on one clock edge: the end of the transmit phase, where the detector is sampled, and a link partner being detected. The bench raises link_partner_active for exactly the last transmit cycle, found by counting tx_en-high cycles, while it presents a valid in-window peak. The run passes only if the fail flag, result code 3 and an all-zero fault word win over the peak. A start write landing inside a running sequence is also provoked mid-phase, and it is judged by unchanged phase lengths and a zero start bit.

// File: rtl/tdr_pkg.sv
// Package for the cable reflection sequencer.
// Holds the phase encoding, result codes, register map and silence decoding.
package tdr_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int LOC_W  = 10;
    localparam int TAP_W  = 7;

    localparam logic [ADDR_W-1:0] A_CFG1  = 5'h10;
    localparam logic [ADDR_W-1:0] A_CFG2  = 5'h11;
    localparam logic [ADDR_W-1:0] A_DUR   = 5'h12;
    localparam logic [ADDR_W-1:0] A_FAULT = 5'h13;
    localparam logic [ADDR_W-1:0] A_CTRL  = 5'h1E;

    localparam logic [DATA_W-1:0] DUR_RST      = 16'd16000;
    localparam logic [TAP_W-1:0]  TAP_LO_RST   = 7'd4;
    localparam logic [TAP_W-1:0]  TAP_HI_RST   = 7'd36;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PRE    = 3'd1,
        ST_TX     = 3'd2,
        ST_POST   = 3'd3,
        ST_FORCED = 3'd4
    } tdr_state_e;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_OPEN   = 2'd1,
        RES_SHORT  = 2'd2,
        RES_LINKED = 2'd3
    } tdr_res_e;

    // Map a 2-bit silence code to a length in milliseconds.
    function automatic logic [DATA_W-1:0] silence_ms(input logic [1:0] code);
        case (code)
            2'd0:    silence_ms = 16'd0;
            2'd1:    silence_ms = 16'd10;
            2'd2:    silence_ms = 16'd100;
            default: silence_ms = 16'd1000;
        endcase
    endfunction

endpackage

// File: rtl/tdr_phase_timer.sv
// Phase timer: counts microsecond ticks, or whole milliseconds built from
// US_PER_MS ticks, and flags expiry once target units have elapsed.
// Assumes: run is high for the whole phase; counters clear on expiry or
// when run is low; a target of zero expires in the first cycle.
module tdr_phase_timer #(
    parameter int US_PER_MS = 1000,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ms_mode,
    input  logic             tick,
    input  logic [CNT_W-1:0] target,
    output logic             expired
);
    localparam int SUB_W = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(US_PER_MS - 1);

    logic [SUB_W-1:0] sub_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sub_last;
    logic             unit_step;
    logic             reach;

    // Decode one elapsed unit and whether it completes the target.
    always_comb begin
        sub_last  = (sub_q == SUB_LAST);
        unit_step = ms_mode ? (tick && sub_last) : tick;
        reach     = ({1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, target};
        expired   = run && ((target == '0) || (unit_step && reach));
    end

    // Advance the sub-millisecond and unit counters.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || expired) begin
            sub_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            if (!ms_mode) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (sub_last) begin
                sub_q <= '0;
                cnt_q <= cnt_q + 1'b1;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdr_fault_eval.sv
// Fault evaluator: turns a detector sample into a fault word and result code.
// Assumes: inputs are stable in the cycle the caller latches the outputs;
// a link-partner fault overrides any peak.
module tdr_fault_eval
    import tdr_pkg::*;
(
    input  logic              peak_found,
    input  logic              peak_sign,
    input  logic [LOC_W-1:0]  peak_loc,
    input  logic [TAP_W-1:0]  tap_lo,
    input  logic [TAP_W-1:0]  tap_hi,
    input  logic              lp_fault,
    output logic [DATA_W-1:0] fault_word,
    output tdr_res_e          res_code
);
    localparam int PAD_W = LOC_W - TAP_W;

    logic in_window;

    // Keep a peak only when it falls inside the tap window.
    always_comb begin
        in_window = peak_found
                 && (peak_loc >= {{PAD_W{1'b0}}, tap_lo})
                 && (peak_loc <= {{PAD_W{1'b0}}, tap_hi});
        fault_word = '0;
        res_code   = RES_OK;
        if (lp_fault) begin
            res_code = RES_LINKED;
        end else if (in_window) begin
            fault_word = {4'b0, 1'b1, peak_sign, peak_loc};
            res_code   = peak_sign ? RES_OPEN : RES_SHORT;
        end
    end

endmodule

// File: rtl/tdr_regfile.sv
// Register file: configuration, start request and run status.
// Assumes: reads are combinational on addr; start writes are dropped while
// busy; accept clears the start request and status, finish loads status.
module tdr_regfile
    import tdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              busy,
    input  logic              accept,
    input  logic              finish,
    input  logic              fin_fail,
    input  tdr_res_e          fin_code,
    input  logic [DATA_W-1:0] fin_fault,
    output logic              start_req,
    output logic [1:0]        pre_code,
    output logic [1:0]        post_code,
    output logic              amp_hi,
    output logic [TAP_W-1:0]  tap_lo,
    output logic [TAP_W-1:0]  tap_hi,
    output logic [DATA_W-1:0] dur_us,
    output logic              done,
    output logic              fail,
    output tdr_res_e          code,
    output logic [DATA_W-1:0] fault
);

    // Configuration registers, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_code  <= 2'd0;
            post_code <= 2'd0;
            amp_hi    <= 1'b0;
            tap_lo    <= TAP_LO_RST;
            tap_hi    <= TAP_HI_RST;
            dur_us    <= DUR_RST;
        end else if (wr) begin
            case (addr)
                A_CFG1: begin
                    pre_code  <= wdata[1:0];
                    post_code <= wdata[3:2];
                    amp_hi    <= wdata[12];
                end
                A_CFG2: begin
                    tap_lo <= wdata[6:0];
                    tap_hi <= wdata[14:8];
                end
                A_DUR:   dur_us <= wdata;
                default: ;
            endcase
        end
    end

    // Start request: set by a write when not busy, self-cleared on accept.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            start_req <= 1'b0;
        end else if (wr && (addr == A_CTRL) && wdata[15] && !busy) begin
            start_req <= 1'b1;
        end
    end

    // Run status: cleared when a run is accepted, loaded when it finishes.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            done  <= 1'b0;
            fail  <= 1'b0;
            code  <= RES_OK;
            fault <= '0;
        end else if (finish) begin
            done  <= 1'b1;
            fail  <= fin_fail;
            code  <= fin_code;
            fault <= fin_fault;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            A_CTRL:  rdata = {start_req, 9'b0, code, 2'b0, done, fail};
            A_CFG1:  rdata = {3'b0, amp_hi, 8'b0, post_code, pre_code};
            A_CFG2:  rdata = {1'b0, tap_hi, 1'b0, tap_lo};
            A_DUR:   rdata = dur_us;
            A_FAULT: rdata = fault;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/cable_tdr_seq.sv
// Cable test reflection sequencer top.
// Steps idle -> pre-silence -> transmit -> post-silence -> forced link.
// Samples the reflection detector on the final transmit cycle, and tracks a
// link partner over the whole transmit phase.
// Assumes: tick_us is a one-cycle pulse; detector inputs are valid at the
// end of transmit.
module cable_tdr_seq
    import tdr_pkg::*;
#(
    parameter int US_PER_MS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_us,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              link_partner_active,
    input  logic              peak_found,
    input  logic              peak_sign,
    input  logic [LOC_W-1:0]  peak_loc,
    output logic              tx_en,
    output logic              tx_amp_hi,
    output logic              force_link,
    output logic [1:0]        result_code
);
    tdr_state_e        state_q;
    tdr_state_e        state_d;
    logic              busy;
    logic              accept;
    logic              expired;
    logic              ms_mode;
    logic [DATA_W-1:0] target;
    logic              start_req;
    logic [1:0]        pre_code;
    logic [1:0]        post_code;
    logic [TAP_W-1:0]  tap_lo;
    logic [TAP_W-1:0]  tap_hi;
    logic [DATA_W-1:0] dur_us;
    logic              done;
    logic              fail;
    tdr_res_e          code;
    logic [DATA_W-1:0] fault;
    logic              lp_seen_q;
    logic              lp_now;
    logic              tx_last;
    logic              finish;
    logic [DATA_W-1:0] eval_fault;
    tdr_res_e          eval_code;
    logic [DATA_W-1:0] hold_fault_q;
    tdr_res_e          hold_code_q;
    logic              hold_fail_q;

    tdr_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .busy      (busy),
        .accept    (accept),
        .finish    (finish),
        .fin_fail  (hold_fail_q),
        .fin_code  (hold_code_q),
        .fin_fault (hold_fault_q),
        .start_req (start_req),
        .pre_code  (pre_code),
        .post_code (post_code),
        .amp_hi    (tx_amp_hi),
        .tap_lo    (tap_lo),
        .tap_hi    (tap_hi),
        .dur_us    (dur_us),
        .done      (done),
        .fail      (fail),
        .code      (code),
        .fault     (fault)
    );

    tdr_phase_timer #(
        .US_PER_MS (US_PER_MS),
        .CNT_W     (DATA_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .ms_mode (ms_mode),
        .tick    (tick_us),
        .target  (target),
        .expired (expired)
    );

    tdr_fault_eval u_eval (
        .peak_found (peak_found),
        .peak_sign  (peak_sign),
        .peak_loc   (peak_loc),
        .tap_lo     (tap_lo),
        .tap_hi     (tap_hi),
        .lp_fault   (lp_now),
        .fault_word (eval_fault),
        .res_code   (eval_code)
    );

    // Phase decode, timer target selection and next-state logic.
    always_comb begin
        busy    = (state_q == ST_PRE) || (state_q == ST_TX) || (state_q == ST_POST);
        accept  = ((state_q == ST_IDLE) || (state_q == ST_FORCED)) && start_req;
        ms_mode = (state_q != ST_TX);
        case (state_q)
            ST_PRE:  target = silence_ms(pre_code);
            ST_POST: target = silence_ms(post_code);
            default: target = dur_us;
        endcase
        tx_last = (state_q == ST_TX) && expired;
        finish  = (state_q == ST_POST) && expired;
        lp_now  = lp_seen_q || ((state_q == ST_TX) && link_partner_active);
        state_d = state_q;
        case (state_q)
            ST_IDLE, ST_FORCED: if (accept)  state_d = ST_PRE;
            ST_PRE:             if (expired) state_d = ST_TX;
            ST_TX:              if (expired) state_d = ST_POST;
            ST_POST:            if (expired) state_d = ST_FORCED;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Link-partner tracker over the transmit phase.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) lp_seen_q <= 1'b0;
        else if (lp_now)      lp_seen_q <= 1'b1;
    end

    // Hold the evaluated result from the last transmit cycle until finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_fault_q <= '0;
            hold_code_q  <= RES_OK;
            hold_fail_q  <= 1'b0;
        end else if (tx_last) begin
            hold_fault_q <= eval_fault;
            hold_code_q  <= eval_code;
            hold_fail_q  <= lp_now;
        end
    end

    // Output decode.
    always_comb begin
        tx_en       = (state_q == ST_TX);
        force_link  = (state_q == ST_FORCED);
        result_code = code;
    end

endmodule

// File: rtl/cable_tdr_seq_chk.sv
// Assertion checker for the cable reflection sequencer, bound to the top.
module cable_tdr_seq_chk
    import tdr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tx_en,
    input logic              force_link,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input tdr_state_e        state_q,
    input logic              busy,
    input logic              start_req,
    input logic              done,
    input logic              fail,
    input tdr_res_e          code,
    input logic [DATA_W-1:0] fault
);
    // R1
    tx_force_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_en && force_link));

    // R1
    tx_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> ($past(state_q) == ST_PRE));

    // R5
    done_with_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_link) |-> done);

    // R6
    busy_start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && (reg_addr == A_CTRL) && reg_wdata[15]) |=> !start_req);

    // R9
    fail_clears_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> ((code == RES_LINKED) && (fault == '0)));

    // R7
    sign_to_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail && fault[11]) |-> (code == (fault[10] ? RES_OPEN : RES_SHORT)));

endmodule

bind cable_tdr_seq cable_tdr_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .force_link (force_link),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .state_q    (state_q),
    .busy       (busy),
    .start_req  (start_req),
    .done       (done),
    .fail       (fail),
    .code       (code),
    .fault      (fault)
);

// File: tb/cable_tdr_seq_tb.sv
// Testbench for the cable reflection sequencer: directed corners plus seeded
// random runs, with expected values from bench functions.
module cable_tdr_seq_tb;
    localparam int UMS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_us = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = 5'h1E;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        link_partner_active = 1'b0;
    logic        peak_found = 1'b0;
    logic        peak_sign = 1'b0;
    logic [9:0]  peak_loc = 10'd0;
    logic        tx_en, tx_amp_hi, force_link;
    logic [1:0]  result_code;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cable_tdr_seq #(.US_PER_MS(UMS)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .link_partner_active(link_partner_active),
        .peak_found(peak_found), .peak_sign(peak_sign), .peak_loc(peak_loc),
        .tx_en(tx_en), .tx_amp_hi(tx_amp_hi), .force_link(force_link),
        .result_code(result_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic int ms_of(input int c);
        return (c == 0) ? 0 : (c == 1) ? 10 : (c == 2) ? 100 : 1000;
    endfunction

    function automatic int max1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic logic [15:0] exp_fault(input bit f, input bit s, input int loc,
                                              input int st, input int en, input bit lp);
        if (lp || !f || loc < st || loc > en) return 16'h0;
        return {4'b0, 1'b1, s, loc[9:0]};
    endfunction

    function automatic int exp_code(input bit f, input bit s, input int loc,
                                    input int st, input int en, input bit lp);
        if (lp) return 3;
        if (!f || loc < st || loc > en) return 0;
        return s ? 1 : 2;
    endfunction

    // One full run. dur < 0 keeps the current duration (default 16000).
    // lpm: 0 none, 1 first transmit cycle, 2 last transmit cycle.
    task automatic run_case(input int pre, input int post, input int dur, input bit amp,
                            input bit f, input bit s, input int loc,
                            input int st, input int en, input int lpm, input int poke);
        int dur_eff, e_pre, e_tx, e_post, n, m, p;
        bit lp;
        logic [15:0] e_ctrl;
        dur_eff = (dur < 0) ? 16000 : dur;
        e_pre  = 1 + max1(ms_of(pre) * UMS);
        e_tx   = max1(dur_eff);
        e_post = max1(ms_of(post) * UMS);
        lp     = (lpm == 1) || (lpm == 2);
        reg_write(5'h10, {3'b0, amp, 8'b0, post[1:0], pre[1:0]});
        reg_write(5'h11, {1'b0, st[6:0], 1'b0, en[6:0]} & 16'h0 | {1'b0, en[6:0], 1'b0, st[6:0]});
        if (dur >= 0) reg_write(5'h12, dur[15:0]);
        peak_found = f; peak_sign = s; peak_loc = loc[9:0];
        // R4: amplitude select passes through
        check(tx_amp_hi == amp, "R4 amplitude", tx_amp_hi, amp);
        reg_write(5'h1E, 16'h8000);
        reg_addr = 5'h1E;
        n = 0;
        while (!tx_en && n < 10000) begin
            if (poke > 0 && n == poke) begin
                reg_wr = 1'b1; reg_wdata = 16'h8000;
            end else begin
                reg_wr = 1'b0;
            end
            // R6: start written while busy stays clear
            if (poke > 0 && n == poke + 2)
                check(reg_rdata[15] == 1'b0, "R6 busy start ignored", reg_rdata[15], 0);
            n++;
            @(negedge clk);
        end
        reg_wr = 1'b0;
        // R2 / R6: pre-silence length
        check(n == e_pre, "R2 pre-silence length", n, e_pre);
        m = 0;
        while (tx_en && m < 70000) begin
            link_partner_active = (lpm == 1 && m == 0) || (lpm == 2 && m == e_tx - 1);
            // R5: start bit self-cleared once running
            if (m == 0) check(reg_rdata[15] == 1'b0, "R5 start self-clear", reg_rdata[15], 0);
            m++;
            @(negedge clk);
        end
        link_partner_active = 1'b0;
        // R3: transmit length
        check(m == e_tx, "R3 transmit length", m, e_tx);
        p = 0;
        while (!force_link && p < 10000) begin
            p++;
            @(negedge clk);
        end
        // R2: post-silence length; R1 ordering into forced link
        check(p == e_post, "R2 post-silence length", p, e_post);
        e_ctrl = {8'b0, 2'b0, 2'(exp_code(f, s, loc, st, en, lp)), 2'b0, 1'b1, lp};
        // R5 / R9: done, fail and result code
        check(reg_rdata == e_ctrl, "R5 R9 control status", reg_rdata, e_ctrl);
        check(result_code == 2'(exp_code(f, s, loc, st, en, lp)), "R7 result code",
              result_code, exp_code(f, s, loc, st, en, lp));
        reg_addr = 5'h13;
        #0;
        // R7 / R8 / R9: fault status word
        check(reg_rdata == exp_fault(f, s, loc, st, en, lp), "R7 R8 fault status",
              reg_rdata, exp_fault(f, s, loc, st, en, lp));
        repeat (3) @(negedge clk);
        // R1: forced link held, transmitter quiet
        check(force_link && !tx_en, "R1 forced link hold", {force_link, tx_en}, 2);
        reg_addr = 5'h1E;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 / R1: reset state
        check(!tx_en && !force_link, "R1 reset outputs", {tx_en, force_link}, 0);
        reg_addr = 5'h10; #1;
        check(reg_rdata == 16'h0000, "R10 cfg1 reset", reg_rdata, 16'h0000);
        reg_addr = 5'h11; #1;
        check(reg_rdata == 16'h2404, "R10 cfg2 reset", reg_rdata, 16'h2404);
        reg_addr = 5'h12; #1;
        check(reg_rdata == 16'h3E80, "R10 duration reset", reg_rdata, 16'h3E80);
        reg_addr = 5'h1E; #1;
        check(reg_rdata == 16'h0000, "R10 control reset", reg_rdata, 16'h0000);

        // R3: default duration, zero silences, in-window open (R7)
        run_case(0, 0, -1, 0, 1, 1, 20, 4, 36, 0, 0);
        // R2: longest silence codes, short peak
        run_case(3, 3, 5, 1, 1, 0, 36, 4, 36, 0, 0);
        // R8: window edges
        run_case(1, 0, 3, 0, 1, 0, 4, 4, 36, 0, 0);
        run_case(0, 1, 3, 0, 1, 1, 37, 4, 36, 0, 0);
        run_case(0, 0, 3, 0, 1, 1, 3, 4, 36, 0, 0);
        // R7: no peak means OK
        run_case(2, 0, 7, 1, 0, 1, 10, 4, 36, 0, 0);
        // R9: link partner on the final transmit cycle, same edge as sampling
        run_case(0, 1, 6, 0, 1, 1, 10, 4, 36, 2, 0);
        // R9: link partner on the first transmit cycle
        run_case(1, 0, 6, 0, 1, 0, 10, 4, 36, 1, 0);
        // R3: zero duration behaves as one tick
        run_case(0, 0, 0, 0, 1, 1, 8, 4, 36, 0, 0);
        // R6: start written during pre-silence
        run_case(1, 1, 4, 1, 1, 1, 12, 4, 36, 0, 3);

        void'($urandom(32'd2718));
        for (int i = 0; i < 25; i++) begin
            int st, en, lm;
            st = int'($urandom % 20);
            en = st + int'($urandom % 30);
            lm = int'($urandom % 4);
            run_case(int'($urandom % 3), int'($urandom % 3), 1 + int'($urandom % 40),
                     1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 64),
                     st, en, (lm == 3) ? 0 : lm, 0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule